// File: doc/BRIEF.md
# Segmented Pointer Address Unit

This unit serves a 16-bit processor whose memory is reached through 64 KB segments. It keeps one 16-bit base register for each of four segment roles (code, data, stack, extra) and turns a pointer into a 20-bit physical address. The physical address is the segment value times sixteen plus the offset. A pointer can be short: a bare 16-bit offset whose segment comes from one of the four base registers. It can also be long: a segment and an offset carried together, with either wrap-in-segment or normalizing arithmetic.

A second port does pointer arithmetic. It adds a 16-bit displacement, or it increments by one. A wrapping long pointer keeps its segment and lets the offset roll over modulo 65536. A normalizing long pointer moves through the full 1 MB space, and its result is rewritten so that the offset is below sixteen. Both ports are independent and can be used in the same cycle. Each result is registered and appears with a valid flag one cycle after its request.

A small output state machine records which result registers were loaded on the last edge. It has four states:
- `ST_IDLE`: no result.
- `ST_ADDR`: address only.
- `ST_ARITH`: arithmetic only.
- `ST_BOTH`: both.

Every state can reach every other state. The next state is chosen from the two request valids: neither gives `ST_IDLE`, address only gives `ST_ADDR`, arithmetic only gives `ST_ARITH`, and both give `ST_BOTH`.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset, all four segment registers read zero, and `phys_valid` and `ar_res_valid` are low.
- R2: For a request accepted on a clock edge, `phys_addr` equals (segment × 16 + offset) modulo 2^20 and `phys_valid` is high in the following cycle. In any cycle that follows an edge without a request, `phys_valid` is low.
- R3: `req_kind` 0 selects a short pointer. Its segment is the base register selected by `req_sel` (0 code, 1 data, 2 stack, 3 extra), and `req_seg` is ignored.
- R4: `req_kind` 1 (wrapping) or 2 (normalizing) uses `req_seg` as the segment and ignores `req_sel`. Code 3 behaves as 1.
- R5: A base register write made on the same edge as a request is not seen by that request. It is seen by the next request.
- R6: `ar_op` 0 adds `ar_delta`. `ar_op` 1 adds one, and `ar_delta` is ignored.
- R7: When `ar_kind` is not 2, the result segment equals the input segment and the result offset is (offset + step) modulo 65536.
- R8: When `ar_kind` is 2, the linear value L = (seg × 16 + off + step) modulo 2^20 is formed. The result segment is L >> 4 and the result offset is L & 15.
- R9: `ar_res_valid` is high in exactly the cycles that follow an edge with `ar_valid` high. The two ports work independently in the same cycle.
- R10: When no new request was taken, `phys_addr`, `ar_res_seg` and `ar_res_off` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Base register write strobe |
| seg_wr_sel | input | 2 | Base register to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Pointer kind: 0 short, 1 wrapping, 2 normalizing |
| req_sel | input | 2 | Base register for short pointers |
| req_seg | input | 16 | Explicit segment for long pointers |
| req_off | input | 16 | Pointer offset |
| phys_valid | output | 1 | Physical address valid |
| phys_addr | output | 20 | Physical address |
| ar_valid | input | 1 | Arithmetic request strobe |
| ar_kind | input | 2 | 2 normalizing, otherwise wrap-in-segment |
| ar_op | input | 1 | 0 add displacement, 1 increment |
| ar_seg | input | 16 | Input pointer segment |
| ar_off | input | 16 | Input pointer offset |
| ar_delta | input | 16 | Displacement |
| ar_res_valid | output | 1 | Arithmetic result valid |
| ar_res_seg | output | 16 | Result segment |
| ar_res_off | output | 16 | Result offset |

## Verification
Some properties are checked on every cycle. These are:
- the one-cycle valid timing of both ports;
- that a wrapping pointer keeps its segment;
- that a normalizing result has an offset below sixteen and keeps the linear position of its input;
- that results hold when idle.

Other behaviours show only in the bench's scenarios, which compare against a behavioural model on every clock. These are the choice of base register for short pointers, the write-then-request ordering, the 1 MB wrap of addresses, and the wrap of a far offset at 65536.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [1:0] {
        PK_NEAR = 2'd0,
        PK_FAR  = 2'd1,
        PK_HUGE = 2'd2,
        PK_RSVD = 2'd3
    } ptr_kind_e;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_ARITH = 2'd2,
        ST_BOTH  = 2'd3
    } out_state_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter int SEG_W = 16,
    parameter int NSEG  = 4,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_data
);
    logic [SEG_W-1:0] bank [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                bank[g] <= wr_data;
            end
        end
    end

    // Read returns the value held before any write on this edge.
    assign rd_data = bank[rd_sel];
endmodule

// File: rtl/phys_addr_gen.sv
module phys_addr_gen #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = OFF_W + SHIFT
) (
    input  logic [OFF_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  addr
);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] ext_off;

    always_comb begin
        base    = {seg, {SHIFT{1'b0}}};
        ext_off = {{SHIFT{1'b0}}, off};
        addr    = base + ext_off;   // carry past bit PA_W-1 is dropped
    end
endmodule

// File: rtl/ptr_arith.sv
module ptr_arith #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = OFF_W + SHIFT
) (
    input  logic             huge,
    input  logic             inc,
    input  logic [OFF_W-1:0] seg_in,
    input  logic [OFF_W-1:0] off_in,
    input  logic [OFF_W-1:0] delta,
    output logic [OFF_W-1:0] seg_out,
    output logic [OFF_W-1:0] off_out
);
    logic [OFF_W-1:0] step;
    logic [PA_W-1:0]  lin;

    always_comb begin
        step = inc ? OFF_W'(1) : delta;
        lin  = {seg_in, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off_in}
             + {{SHIFT{1'b0}}, step};
        if (huge) begin
            seg_out = lin[PA_W-1:SHIFT];
            off_out = {{(OFF_W-SHIFT){1'b0}}, lin[SHIFT-1:0]};
        end else begin
            seg_out = seg_in;
            off_out = off_in + step;
        end
    end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
    import seg_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int NSEG  = 4,
    localparam int PA_W  = OFF_W + SHIFT,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_wr_en,
    input  logic [SEL_W-1:0] seg_wr_sel,
    input  logic [OFF_W-1:0] seg_wr_data,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [OFF_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    output logic             phys_valid,
    output logic [PA_W-1:0]  phys_addr,
    input  logic             ar_valid,
    input  logic [1:0]       ar_kind,
    input  logic             ar_op,
    input  logic [OFF_W-1:0] ar_seg,
    input  logic [OFF_W-1:0] ar_off,
    input  logic [OFF_W-1:0] ar_delta,
    output logic             ar_res_valid,
    output logic [OFF_W-1:0] ar_res_seg,
    output logic [OFF_W-1:0] ar_res_off
);
    out_state_e       state, state_nx;
    ptr_kind_e        rq_kind, op_kind;
    logic [OFF_W-1:0] base_rd, eff_seg;
    logic [PA_W-1:0]  addr_c;
    logic [OFF_W-1:0] seg_c, off_c;

    assign rq_kind = ptr_kind_e'(req_kind);
    assign op_kind = ptr_kind_e'(ar_kind);

    seg_regfile #(.SEG_W(OFF_W), .NSEG(NSEG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .rd_sel  (req_sel),
        .rd_data (base_rd)
    );

    always_comb begin
        unique case (rq_kind)
            PK_NEAR: eff_seg = base_rd;
            PK_FAR,
            PK_HUGE,
            PK_RSVD: eff_seg = req_seg;
        endcase
    end

    phys_addr_gen #(.OFF_W(OFF_W), .SHIFT(SHIFT)) u_agen (
        .seg  (eff_seg),
        .off  (req_off),
        .addr (addr_c)
    );

    ptr_arith #(.OFF_W(OFF_W), .SHIFT(SHIFT)) u_arith (
        .huge    (op_kind == PK_HUGE),
        .inc     (ar_op),
        .seg_in  (ar_seg),
        .off_in  (ar_off),
        .delta   (ar_delta),
        .seg_out (seg_c),
        .off_out (off_c)
    );

    // Next-state choice from the two request strobes.
    always_comb begin
        unique case ({req_valid, ar_valid})
            2'b00: state_nx = ST_IDLE;
            2'b10: state_nx = ST_ADDR;
            2'b01: state_nx = ST_ARITH;
            2'b11: state_nx = ST_BOTH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phys_addr  <= '0;
            ar_res_seg <= '0;
            ar_res_off <= '0;
        end else begin
            if (req_valid) phys_addr <= addr_c;
            if (ar_valid) begin
                ar_res_seg <= seg_c;
                ar_res_off <= off_c;
            end
        end
    end

    always_comb begin
        phys_valid   = 1'b0;
        ar_res_valid = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ADDR:  phys_valid = 1'b1;
            ST_ARITH: ar_res_valid = 1'b1;
            ST_BOTH: begin
                phys_valid   = 1'b1;
                ar_res_valid = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int NSEG  = 4,
    localparam int PA_W  = OFF_W + SHIFT,
    localparam int SEL_W = $clog2(NSEG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seg_wr_en,
    input logic [SEL_W-1:0] seg_wr_sel,
    input logic [OFF_W-1:0] seg_wr_data,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic [SEL_W-1:0] req_sel,
    input logic [OFF_W-1:0] req_seg,
    input logic [OFF_W-1:0] req_off,
    input logic             phys_valid,
    input logic [PA_W-1:0]  phys_addr,
    input logic             ar_valid,
    input logic [1:0]       ar_kind,
    input logic             ar_op,
    input logic [OFF_W-1:0] ar_seg,
    input logic [OFF_W-1:0] ar_off,
    input logic [OFF_W-1:0] ar_delta,
    input logic             ar_res_valid,
    input logic [OFF_W-1:0] ar_res_seg,
    input logic [OFF_W-1:0] ar_res_off
);
    logic [PA_W-1:0] lin_in, lin_out;
    logic            huge_req;

    assign huge_req = ar_valid && (ar_kind == 2'd2);
    assign lin_in   = {ar_seg, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, ar_off}
                    + (ar_op ? PA_W'(1) : {{SHIFT{1'b0}}, ar_delta});
    assign lin_out  = {ar_res_seg, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, ar_res_off};

    // R2
    phys_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> phys_valid);
    // R2
    phys_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !phys_valid);
    // R9
    arith_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |=> ar_res_valid);
    // R9
    arith_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ar_valid |=> !ar_res_valid);
    // R7
    far_seg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_kind != 2'd2) |=> ar_res_seg == $past(ar_seg));
    // R8
    huge_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        huge_req |=> ar_res_off[OFF_W-1:SHIFT] == '0);
    // R8
    huge_lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        huge_req |=> lin_out == $past(lin_in));
    // R10
    phys_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(phys_addr));
    // R10
    arith_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ar_valid |=> ($stable(ar_res_seg) && $stable(ar_res_off)));
endmodule

bind seg_addr_unit seg_addr_unit_chk #(.OFF_W(OFF_W), .SHIFT(SHIFT), .NSEG(NSEG)) u_chk (.*);

// File: tb/seg_addr_unit_tb.sv
`timescale 1ns/1ps
module seg_addr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_sel = '0;
    logic [15:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic        phys_valid;
    logic [19:0] phys_addr;
    logic        ar_valid = 1'b0;
    logic [1:0]  ar_kind = '0;
    logic        ar_op = 1'b0;
    logic [15:0] ar_seg = '0;
    logic [15:0] ar_off = '0;
    logic [15:0] ar_delta = '0;
    logic        ar_res_valid;
    logic [15:0] ar_res_seg;
    logic [15:0] ar_res_off;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    seg_addr_unit u_dut (.*);

    // Behavioural reference model
    int    m_seg [4];
    bit    e_pv, e_av;
    int    e_pa, e_as, e_ao;
    string e_ptag = "R1";
    string e_atag = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_seg[i]) m_seg[i] = 0;
            e_pv = 0; e_av = 0; e_pa = 0; e_as = 0; e_ao = 0;
            e_ptag = "R1"; e_atag = "R1";
        end else begin
            e_pv = req_valid;
            if (req_valid) begin
                int s;
                s = (req_kind == 0) ? m_seg[req_sel] : int'(req_seg);
                e_pa = (s * 16 + int'(req_off)) % 1048576;
                e_ptag = (req_kind == 0) ? (seg_wr_en ? "R5" : "R3") : "R4";
            end else e_ptag = "R10";
            e_av = ar_valid;
            if (ar_valid) begin
                int d, lin;
                d = ar_op ? 1 : int'(ar_delta);
                if (ar_kind == 2) begin
                    lin  = (int'(ar_seg) * 16 + int'(ar_off) + d) % 1048576;
                    e_as = lin / 16;
                    e_ao = lin % 16;
                    e_atag = "R8";
                end else begin
                    e_as = ar_seg;
                    e_ao = (int'(ar_off) + d) % 65536;
                    e_atag = ar_op ? "R6" : "R7";
                end
            end else e_atag = "R10";
            if (seg_wr_en) m_seg[seg_wr_sel] = seg_wr_data;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (!done) begin
            chk(rst_n ? "R2" : "R1", "phys_valid", int'(phys_valid), int'(e_pv));
            chk(rst_n ? "R9" : "R1", "ar_res_valid", int'(ar_res_valid), int'(e_av));
            chk(e_ptag, "phys_addr", int'(phys_addr), e_pa);
            chk(e_atag, "ar_res_seg", int'(ar_res_seg), e_as);
            chk(e_atag, "ar_res_off", int'(ar_res_off), e_ao);
        end
    end

    task automatic idle();
        @(negedge clk);
        seg_wr_en = 0; req_valid = 0; ar_valid = 0;
    endtask

    task automatic wr_seg(int sel, int val);
        @(negedge clk);
        req_valid = 0; ar_valid = 0;
        seg_wr_en = 1; seg_wr_sel = 2'(sel); seg_wr_data = 16'(val);
    endtask

    task automatic rq(int kind, int sel, int seg, int off);
        @(negedge clk);
        seg_wr_en = 0; ar_valid = 0;
        req_valid = 1; req_kind = 2'(kind); req_sel = 2'(sel);
        req_seg = 16'(seg); req_off = 16'(off);
    endtask

    task automatic ar(int kind, int op, int seg, int off, int dl);
        @(negedge clk);
        seg_wr_en = 0; req_valid = 0;
        ar_valid = 1; ar_kind = 2'(kind); ar_op = 1'(op);
        ar_seg = 16'(seg); ar_off = 16'(off); ar_delta = 16'(dl);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: base registers read zero after reset
        rq(0, 0, 16'h9999, 16'h0010);
        rq(0, 3, 16'h9999, 16'h0020);
        // R3: each base register chosen by req_sel
        wr_seg(0, 16'h1000); wr_seg(1, 16'h2345); wr_seg(2, 16'h8000); wr_seg(3, 16'hF000);
        for (int k = 0; k < 4; k++) rq(0, k, 16'hAAAA, 16'h1234);
        // R4: explicit segment, req_sel ignored; 1 MB wrap (R2)
        rq(1, 2, 16'hFFFF, 16'hFFFF);
        rq(2, 1, 16'hF000, 16'h0010);
        rq(3, 0, 16'h0001, 16'h0001);
        idle(); idle();
        // R5: write and request on the same edge
        @(negedge clk);
        ar_valid = 0;
        seg_wr_en = 1; seg_wr_sel = 2'd1; seg_wr_data = 16'h0500;
        req_valid = 1; req_kind = 2'd0; req_sel = 2'd1; req_off = 16'h0004;
        rq(0, 1, 0, 16'h0004);
        // R7: far offset wraps, segment kept
        ar(1, 0, 16'h1234, 16'hFFF0, 16'h0020);
        ar(0, 1, 16'h4321, 16'hFFFF, 16'h7777);
        // R6: increment ignores delta
        ar(1, 1, 16'h0000, 16'h0005, 16'hFFFF);
        // R8: normalizing crosses 64 KB and wraps at 1 MB
        ar(2, 0, 16'h1000, 16'hFFF0, 16'h0020);
        ar(2, 1, 16'hFFFF, 16'h000F, 16'h0000);
        ar(2, 0, 16'h0123, 16'h0008, 16'h0009);
        idle(); idle();
        // R9: both ports in the same cycle, then random traffic
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            seg_wr_en = 1'($urandom); seg_wr_sel = 2'($urandom); seg_wr_data = 16'($urandom);
            req_valid = 1'($urandom); req_kind = 2'($urandom); req_sel = 2'($urandom);
            req_seg = 16'($urandom); req_off = 16'($urandom);
            ar_valid = 1'($urandom); ar_kind = 2'($urandom); ar_op = 1'($urandom);
            ar_seg = 16'($urandom); ar_off = 16'($urandom); ar_delta = 16'($urandom);
        end
        idle(); idle(); idle();
        @(negedge clk);
        #2;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule